// File: doc/BRIEF.md
# Link Power-State Exit Sequencer

This block sits in the transmit path of a serial link. It decides which training ordered sets go to the symbol encoder, and how many, when the link wakes from a low-power state. It also holds the link-control bits that steer that behaviour. The block moves the link between a small set of states: L0, L0s, L1, Recovery and Disabled. In Disabled the transmitter is in electrical idle. The block does not model any other training state.

A fast-resume request from L0s triggers a burst of fast-training sets followed by a single skip set, and the link then returns to L0. A wake request from L1 triggers a burst of TS1 sets, and the link then goes to Recovery. An extended-sync control bit replaces the normal short bursts with fixed long bursts. These long bursts give an external observer time to lock onto the bit stream. Software can retrain the link or disable it through register bits. Re-enabling the link is delayed by a minimum idle time.

Top module: `link_exit_seq`

## Requirements
- R1: After reset, link_state_o is 0 (L0), os_valid_o is 0 and cfg_rdata_o is 0.
- R2: With extended sync set (register bit 7), an exit from L0s sends exactly FTS_LONG (4096) sets of type 1 (FTS), then exactly one set of type 2 (SKP), and only after that set is accepted does link_state_o become 0 (L0). While these sets are sent, link_state_o stays 1 (L0s).
- R3: With extended sync set, an exit from L1 sends exactly TS1_LONG (1024) sets of type 3 (TS1), and link_state_o then becomes 3 (Recovery). While these sets are sent, link_state_o stays 2 (L1).
- R4: With extended sync clear, an L0s exit sends NFTS FTS sets plus one SKP set, and an L1 exit sends TS1_SHORT TS1 sets.
- R5: A set is consumed only in a cycle where os_valid_o and os_ready_i are both high. While os_ready_i is low, os_valid_o and os_type_o hold their values and the burst count does not advance.
- R6: Writing 1 to bit 5 (retrain) while in L0 moves the link to Recovery on the next cycle. Bit 5 always reads 0.
- R7: A retrain write made while an exit is waiting or in progress does not interrupt it. For an L0s exit, the link reaches L0 and then enters Recovery one cycle later.
- R8: Setting bit 4 (disable) moves the link to state 4 (Disabled) from any state, aborting any burst, and os_valid_o stays low while the link is Disabled.
- R9: After bit 4 is cleared, the link leaves Disabled for Recovery only once it has spent MIN_IDLE+1 cycles in Disabled.
- R10: Bit 0 (completion boundary) always reads 0 and ignores writes. Bits 6 (common clock), 7 (extended sync) and 4 read back what was written. All other bits read 0.
- R11: In Recovery, a pulse on recov_done_i returns the link to L0.
- R12: In L0, l1_enter_i moves the link to L1 (state 2) and l0s_enter_i moves it to L0s (state 1). If both are asserted together, L1 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write data |
| cfg_rdata_o | output | 16 | Control register read data |
| l0s_enter_i | input | 1 | Request to enter L0s from L0 |
| l1_enter_i | input | 1 | Request to enter L1 from L0 |
| lp_exit_i | input | 1 | Request to leave the current low-power state |
| recov_done_i | input | 1 | Recovery complete, return to L0 |
| os_ready_i | input | 1 | Encoder accepts an ordered set this cycle |
| os_valid_o | output | 1 | Ordered set offered this cycle |
| os_type_o | output | 2 | Set type: 1 FTS, 2 SKP, 3 TS1 |
| link_state_o | output | 3 | 0 L0, 1 L0s, 2 L1, 3 Recovery, 4 Disabled |

## Verification
On every cycle the checker confirms several properties. Burst lengths are counted independently and compared with the extended-sync setting that was in force when each burst began. Offered sets must stay stable while the encoder stalls. The link must stay silent while Disabled, the minimum idle time in Disabled must be met, and the retrain and completion-boundary bits must read zero. Other behaviours show up only in the bench scenarios: the priority between entry requests, a retrain deferred until an exit burst ends, a burst aborted by a disable write, and the return from Recovery.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;
  typedef enum logic [2:0] {
    LS_L0 = 3'd0, LS_L0S = 3'd1, LS_L1 = 3'd2, LS_RCV = 3'd3, LS_DIS = 3'd4
  } lstate_e;

  typedef enum logic [1:0] {
    OS_NONE = 2'd0, OS_FTS = 2'd1, OS_SKP = 2'd2, OS_TS1 = 2'd3
  } os_e;

  typedef enum logic [2:0] {
    PH_L0, PH_L0S, PH_L1, PH_FTS, PH_SKP, PH_TS1, PH_RCV, PH_DIS
  } phase_e;

  localparam int unsigned REG_W = 16;
  localparam int unsigned B_RCB = 0;
  localparam int unsigned B_DIS = 4;
  localparam int unsigned B_RTR = 5;
  localparam int unsigned B_CC  = 6;
  localparam int unsigned B_EXT = 7;
endpackage

// File: rtl/lnk_ctrl_regs.sv
module lnk_ctrl_regs
  import link_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             dis_o,
  output logic             ext_o,
  output logic             retrain_o
);
  logic dis_q, cc_q, ext_q;
  logic unused_wbits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= 1'b0;
      cc_q  <= 1'b0;
      ext_q <= 1'b0;
    end else if (we_i) begin
      dis_q <= wdata_i[B_DIS];
      cc_q  <= wdata_i[B_CC];
      ext_q <= wdata_i[B_EXT];
    end
  end

  // retrain is write-only: a pulse, never stored
  assign retrain_o = we_i & wdata_i[B_RTR];
  assign dis_o     = dis_q;
  assign ext_o     = ext_q;
  assign unused_wbits = ^{wdata_i[REG_W-1:B_EXT+1], wdata_i[B_DIS-1:0]};

  always_comb begin
    rdata_o        = '0;
    rdata_o[B_DIS] = dis_q;
    rdata_o[B_CC]  = cc_q;
    rdata_o[B_EXT] = ext_q;
  end
endmodule

// File: rtl/burst_ctr.sv
module burst_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned MIN_IDLE = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(MIN_IDLE + 1);
  localparam logic [W-1:0] LIM = W'(MIN_IDLE);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/exit_fsm.sv
module exit_fsm
  import link_seq_pkg::*;
#(
  parameter int unsigned FTS_LONG  = 4096,
  parameter int unsigned TS1_LONG  = 1024,
  parameter int unsigned NFTS      = 32,
  parameter int unsigned TS1_SHORT = 16,
  parameter int unsigned CNT_W     = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l0s_enter_i,
  input  logic             l1_enter_i,
  input  logic             lp_exit_i,
  input  logic             recov_done_i,
  input  logic             retrain_i,
  input  logic             dis_i,
  input  logic             ext_i,
  input  logic             idle_done_i,
  input  logic             last_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             dec_o,
  output logic             os_valid_o,
  output logic [1:0]       os_type_o,
  output logic [2:0]       link_state_o
);
  phase_e ph_q, ph_n;
  logic   pend_q, pend_n;
  logic   acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_L0;
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      pend_q <= pend_n;
    end
  end

  assign acc = os_valid_o & ready_i;

  always_comb begin
    ph_n       = ph_q;
    pend_n     = pend_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (dis_i) begin
      ph_n   = PH_DIS;
      pend_n = 1'b0;
    end else begin
      unique case (ph_q)
        PH_L0: begin
          if (retrain_i || pend_q) begin
            ph_n   = PH_RCV;
            pend_n = 1'b0;
          end else if (l1_enter_i)  ph_n = PH_L1;
          else if (l0s_enter_i)     ph_n = PH_L0S;
        end
        PH_L0S: begin
          if (retrain_i) pend_n = 1'b1;
          if (lp_exit_i) begin
            ph_n       = PH_FTS;
            load_o     = 1'b1;
            load_val_o = ext_i ? CNT_W'(FTS_LONG - 1) : CNT_W'(NFTS - 1);
          end
        end
        PH_L1: begin
          if (retrain_i) pend_n = 1'b1;
          if (lp_exit_i) begin
            ph_n       = PH_TS1;
            load_o     = 1'b1;
            load_val_o = ext_i ? CNT_W'(TS1_LONG - 1) : CNT_W'(TS1_SHORT - 1);
          end
        end
        PH_FTS: begin
          if (retrain_i) pend_n = 1'b1;
          if (acc && last_i) ph_n = PH_SKP;
        end
        PH_SKP: begin
          if (retrain_i) pend_n = 1'b1;
          if (acc) ph_n = PH_L0;
        end
        PH_TS1: begin
          if (retrain_i) pend_n = 1'b1;
          if (acc && last_i) begin
            ph_n   = PH_RCV;
            pend_n = 1'b0; // Recovery satisfies a pending retrain
          end
        end
        PH_RCV:  if (recov_done_i) ph_n = PH_L0;
        PH_DIS:  if (idle_done_i)  ph_n = PH_RCV;
        default: ph_n = PH_L0;
      endcase
    end
  end

  always_comb begin
    os_valid_o   = 1'b0;
    os_type_o    = OS_NONE;
    link_state_o = LS_L0;
    unique case (ph_q)
      PH_L0:   link_state_o = LS_L0;
      PH_L0S:  link_state_o = LS_L0S;
      PH_L1:   link_state_o = LS_L1;
      PH_FTS:  begin link_state_o = LS_L0S; os_valid_o = 1'b1; os_type_o = OS_FTS; end
      PH_SKP:  begin link_state_o = LS_L0S; os_valid_o = 1'b1; os_type_o = OS_SKP; end
      PH_TS1:  begin link_state_o = LS_L1;  os_valid_o = 1'b1; os_type_o = OS_TS1; end
      PH_RCV:  link_state_o = LS_RCV;
      PH_DIS:  link_state_o = LS_DIS;
      default: link_state_o = LS_L0;
    endcase
  end

  assign dec_o = acc & ((ph_q == PH_FTS) | (ph_q == PH_TS1));
endmodule

// File: rtl/link_exit_seq.sv
module link_exit_seq
  import link_seq_pkg::*;
#(
  parameter int unsigned FTS_LONG  = 4096,
  parameter int unsigned TS1_LONG  = 1024,
  parameter int unsigned NFTS      = 32,
  parameter int unsigned TS1_SHORT = 16,
  parameter int unsigned MIN_IDLE  = 200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [15:0] cfg_rdata_o,
  input  logic        l0s_enter_i,
  input  logic        l1_enter_i,
  input  logic        lp_exit_i,
  input  logic        recov_done_i,
  input  logic        os_ready_i,
  output logic        os_valid_o,
  output logic [1:0]  os_type_o,
  output logic [2:0]  link_state_o
);
  localparam int unsigned MAX_A   = (FTS_LONG > NFTS) ? FTS_LONG : NFTS;
  localparam int unsigned MAX_B   = (TS1_LONG > TS1_SHORT) ? TS1_LONG : TS1_SHORT;
  localparam int unsigned MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  logic             dis, ext, retrain, idle_done, last, load, dec;
  logic [CNT_W-1:0] load_val;

  lnk_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .dis_o     (dis),
    .ext_o     (ext),
    .retrain_o (retrain)
  );

  burst_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .dec_i      (dec),
    .last_o     (last)
  );

  idle_timer #(.MIN_IDLE(MIN_IDLE)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (link_state_o == LS_DIS),
    .done_o (idle_done)
  );

  exit_fsm #(
    .FTS_LONG (FTS_LONG),
    .TS1_LONG (TS1_LONG),
    .NFTS     (NFTS),
    .TS1_SHORT(TS1_SHORT),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .l0s_enter_i  (l0s_enter_i),
    .l1_enter_i   (l1_enter_i),
    .lp_exit_i    (lp_exit_i),
    .recov_done_i (recov_done_i),
    .retrain_i    (retrain),
    .dis_i        (dis),
    .ext_i        (ext),
    .idle_done_i  (idle_done),
    .last_i       (last),
    .ready_i      (os_ready_i),
    .load_o       (load),
    .load_val_o   (load_val),
    .dec_o        (dec),
    .os_valid_o   (os_valid_o),
    .os_type_o    (os_type_o),
    .link_state_o (link_state_o)
  );
endmodule

// File: rtl/link_exit_seq_chk.sv
module link_exit_seq_chk
  import link_seq_pkg::*;
#(
  parameter int unsigned FTS_LONG  = 4096,
  parameter int unsigned TS1_LONG  = 1024,
  parameter int unsigned NFTS      = 32,
  parameter int unsigned TS1_SHORT = 16,
  parameter int unsigned MIN_IDLE  = 200
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cfg_rdata_o,
  input logic        os_ready_i,
  input logic        os_valid_o,
  input logic [1:0]  os_type_o,
  input logic [2:0]  link_state_o
);
  int unsigned acc_cnt, dis_cnt;
  logic        ext_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt <= 0;
      dis_cnt <= 0;
      ext_l   <= 1'b0;
    end else begin
      if (!os_valid_o) acc_cnt <= 0;
      else if (os_ready_i && os_type_o != OS_SKP) acc_cnt <= acc_cnt + 1;
      if (!os_valid_o) ext_l <= cfg_rdata_o[B_EXT];
      dis_cnt <= (link_state_o == LS_DIS) ? dis_cnt + 1 : 0;
    end
  end

  // R2 and R4: FTS count at the SKP handoff
  p_fts_burst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_valid_o && os_ready_i && os_type_o == OS_SKP) |->
      acc_cnt == (ext_l ? FTS_LONG : NFTS));

  p_fts_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_valid_o && os_type_o != OS_TS1) |-> link_state_o == LS_L0S);

  // R3 and R4: TS1 count on arrival in Recovery from L1
  p_ts1_burst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == LS_RCV && $past(link_state_o) == LS_L1) |->
      acc_cnt == (ext_l ? TS1_LONG : TS1_SHORT));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_valid_o && !os_ready_i && cfg_rdata_o[B_DIS] == 1'b0) |=>
      (os_valid_o && $stable(os_type_o)));

  p_rtr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[B_RTR] == 1'b0);

  p_dis_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == LS_DIS) |-> !os_valid_o);

  p_idle_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o != LS_DIS && $past(link_state_o) == LS_DIS) |->
      $past(dis_cnt) >= MIN_IDLE);

  p_rcb_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[B_RCB] == 1'b0);
endmodule

bind link_exit_seq link_exit_seq_chk #(
  .FTS_LONG (FTS_LONG),
  .TS1_LONG (TS1_LONG),
  .NFTS     (NFTS),
  .TS1_SHORT(TS1_SHORT),
  .MIN_IDLE (MIN_IDLE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_rdata_o  (cfg_rdata_o),
  .os_ready_i   (os_ready_i),
  .os_valid_o   (os_valid_o),
  .os_type_o    (os_type_o),
  .link_state_o (link_state_o)
);

// File: tb/link_exit_seq_tb.sv
module link_exit_seq_tb;
  localparam int FTS_LONG = 4096, TS1_LONG = 1024, NFTS = 32, TS1_SHORT = 16, MIN_IDLE = 200;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic        l0s_en = 1'b0, l1_en = 1'b0, lp_exit = 1'b0, recov = 1'b0, os_ready = 1'b0;
  logic        os_valid;
  logic [1:0]  os_type;
  logic [2:0]  lstate;

  int checks = 0, fails = 0;
  bit sh_ext = 0, sh_cc = 0, sh_dis = 0;

  always #10 clk = ~clk;

  link_exit_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .l0s_enter_i(l0s_en), .l1_enter_i(l1_en),
    .lp_exit_i(lp_exit), .recov_done_i(recov), .os_ready_i(os_ready),
    .os_valid_o(os_valid), .os_type_o(os_type), .link_state_o(lstate)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  function automatic int exp_len(input bit ext, input bit l1);
    if (l1) return ext ? TS1_LONG : TS1_SHORT;
    return ext ? FTS_LONG : NFTS;
  endfunction

  function automatic logic [15:0] exp_rd();
    logic [15:0] w = '0;
    w[7] = sh_ext; w[6] = sh_cc; w[4] = sh_dis;
    return w;
  endfunction

  task automatic set_ctrl(input bit ext, input bit cc, input bit dis, input bit rtr, input bit rcb);
    @(negedge clk);
    cfg_wdata = 16'hFF00 | {8'h0, ext, cc, rtr, dis, 3'b101, rcb};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    sh_ext = ext; sh_cc = cc; sh_dis = dis;
  endtask

  // mask: bit0 l0s, bit1 l1, bit2 exit, bit3 recov_done
  task automatic pulse_in(input logic [3:0] m);
    @(negedge clk);
    {recov, lp_exit, l1_en, l0s_en} = m;
    @(negedge clk);
    {recov, lp_exit, l1_en, l0s_en} = 4'b0;
  endtask

  task automatic run_burst(input logic [1:0] t, input logic [2:0] end_st, input int pct,
                           output int n, output int skp, output int other);
    n = 0; skp = 0; other = 0;
    for (int i = 0; i < 60000; i++) begin
      if (lstate == end_st && !os_valid) break;
      os_ready = ($urandom_range(99) < pct);
      if (os_valid && os_ready) begin
        if (os_type == t) n++;
        else if (os_type == 2'd2) skp++;
        else other++;
      end
      @(negedge clk);
    end
    os_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    int n, skp, oth, c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(lstate == 3'd0, "R1 state", lstate, 0);
    chk(!os_valid, "R1 valid", os_valid, 0);
    chk(cfg_rdata == 16'h0, "R1 rdata", cfg_rdata, 0);

    // R12: both entries at once, L1 wins
    pulse_in(4'b0011);
    chk(lstate == 3'd2, "R12 l1 priority", lstate, 2);
    // R4: short TS1 burst
    pulse_in(4'b0100);
    run_burst(2'd3, 3'd3, 100, n, skp, oth);
    chk(n == TS1_SHORT && oth == 0 && skp == 0, "R4 ts1 short", n, TS1_SHORT);
    chk(lstate == 3'd3, "R4 to recovery", lstate, 3);
    pulse_in(4'b1000);
    chk(lstate == 3'd0, "R11 recov done", lstate, 0);

    pulse_in(4'b0001);
    chk(lstate == 3'd1, "R12 l0s entry", lstate, 1);
    pulse_in(4'b0100);
    run_burst(2'd1, 3'd0, 100, n, skp, oth);
    chk(n == NFTS && oth == 0, "R4 fts short", n, NFTS);
    chk(skp == 1, "R4 single skp", skp, 1);

    // R10: rcb ignored, rw bits read back
    set_ctrl(1, 1, 0, 0, 1);
    chk(cfg_rdata == exp_rd(), "R10 readback", cfg_rdata, exp_rd());

    // R2 and R5: long FTS with random stalls
    pulse_in(4'b0001);
    pulse_in(4'b0100);
    run_burst(2'd1, 3'd0, 60, n, skp, oth);
    chk(n == FTS_LONG && oth == 0, "R2 fts long", n, FTS_LONG);
    chk(skp == 1, "R2 skp then L0", skp, 1);
    chk(lstate == 3'd0, "R2 state L0", lstate, 0);

    // R3 and R5: long TS1 with stalls
    pulse_in(4'b0010);
    pulse_in(4'b0100);
    run_burst(2'd3, 3'd3, 45, n, skp, oth);
    chk(n == TS1_LONG && skp == 0 && oth == 0, "R3 ts1 long", n, TS1_LONG);
    chk(lstate == 3'd3, "R3 to recovery", lstate, 3);
    pulse_in(4'b1000);

    // R6: retrain from L0
    set_ctrl(0, 1, 0, 1, 0);
    chk(lstate == 3'd3, "R6 retrain", lstate, 3);
    chk(cfg_rdata[5] == 1'b0, "R6 reads zero", cfg_rdata[5], 0);
    pulse_in(4'b1000);

    // R7: retrain during an L0s exit burst is deferred
    pulse_in(4'b0001);
    pulse_in(4'b0100);
    set_ctrl(0, 1, 0, 1, 0);
    chk(lstate == 3'd1 && os_valid, "R7 burst continues", lstate, 1);
    run_burst(2'd1, 3'd0, 100, n, skp, oth);
    chk(n == NFTS && skp == 1, "R7 burst complete", n, NFTS);
    @(negedge clk);
    chk(lstate == 3'd3, "R7 deferred retrain", lstate, 3);
    pulse_in(4'b1000);

    // R8: disable aborts TS1 burst
    pulse_in(4'b0010);
    pulse_in(4'b0100);
    set_ctrl(0, 1, 1, 0, 0);
    @(negedge clk);
    chk(lstate == 3'd4, "R8 disabled", lstate, 4);
    chk(!os_valid, "R8 silent", os_valid, 0);
    chk(cfg_rdata == exp_rd(), "R10 dis readback", cfg_rdata, exp_rd());

    // R9: minimum idle before re-enable
    c = 0;
    set_ctrl(0, 1, 0, 0, 0);
    c += 2;
    while (lstate == 3'd4 && c < 5000) begin
      @(negedge clk);
      c++;
    end
    chk(c == MIN_IDLE + 1, "R9 idle time", c, MIN_IDLE + 1);
    chk(lstate == 3'd3, "R9 to recovery", lstate, 3);
    pulse_in(4'b1000);

    // random exits
    for (int k = 0; k < 6; k++) begin
      bit ext_r = 1'($urandom_range(1));
      bit l1_r  = 1'($urandom_range(1));
      int pct   = 30 + $urandom_range(70);
      set_ctrl(ext_r, 1'($urandom_range(1)), 0, 0, 1'($urandom_range(1)));
      chk(cfg_rdata == exp_rd(), "R10 rand readback", cfg_rdata, exp_rd());
      pulse_in(l1_r ? 4'b0010 : 4'b0001);
      pulse_in(4'b0100);
      run_burst(l1_r ? 2'd3 : 2'd1, l1_r ? 3'd3 : 3'd0, pct, n, skp, oth);
      chk(n == exp_len(ext_r, l1_r) && oth == 0, "R5 rand burst", n, exp_len(ext_r, l1_r));
      chk(skp == (l1_r ? 0 : 1), "R2 rand skp", skp, l1_r ? 0 : 1);
      if (l1_r) pulse_in(4'b1000);
      chk(lstate == 3'd0, "R11 rand L0", lstate, 0);
    end

    report();
  end
endmodule